// File: doc/BRIEF.md
# Double-Buffered Transmit Mailbox

This block is the transmit half of a byte-oriented data exchange between a host and a line interface through shared storage. The host sees two mailboxes, A-slot 0 and slot 1, each with room for `BUF_BYTES` data bytes and one count word. The host fills a slot's bytes and then writes the number of valid bytes into the slot's count word. While transmission is running, the block claims the slots strictly in turn. For each claimed slot it copies the bytes into an internal byte queue, zeroes the count word and pulses a per-slot "slot free" interrupt.

The queue feeds a serializer. The serializer presents one bit at a time with a valid flag, least significant bit first, and the line side accepts each bit with a one-cycle enable. A single command input toggles transmission. The first pulse starts it at slot 0. The next pulse requests a stop, which takes effect only after the slots already posted in turn have been sent. While running, the block flags an underrun when no slot holds a usable count and nothing is left to shift out.

Top module: `tx_mailbox`

## Requirements
- R1: After a synchronous active-low reset, both count words read 0, `tx_valid`, `tx_active`, `err_irq` and `buf_free_irq` are 0.
- R2: Host write map: with `wr_addr[4]`=0, `wr_addr[3]` selects the slot and `wr_addr[2:0]` the byte. With `wr_addr[4]`=1, `wr_addr[0]` selects the slot's count word. A data write to a slot whose count word is nonzero is ignored. Count word writes are always accepted. `status_words[7:0]` is slot 0's count and `status_words[15:8]` is slot 1's count.
- R3: When a slot is claimed, its count word reads 0 and `buf_free_irq[slot]` is high for exactly one cycle. At most one bit of `buf_free_irq` is high at a time.
- R4: A command pulse while idle starts transmission (`tx_active`=1). The first slot claimed is slot 0, and claims then strictly alternate 0,1,0,1.
- R5: The bytes of a slot are sent in index order, each least significant bit first. A bit is consumed on a cycle where `tx_valid` and `bit_en` are both 1. While `tx_valid`=1 and `bit_en`=0, `tx_bit` holds its value.
- R6: A slot is claimed only when the byte queue has room for `BUF_BYTES` more bytes. Otherwise its count word stays unchanged.
- R7: While running (not stopping), if neither slot holds a usable count and the queue and serializer are empty, `err_irq` pulses for one cycle on entry to that condition.
- R8: A count of 0 or of more than `BUF_BYTES` makes the slot empty. Such a slot is never claimed, and its count word keeps its value.
- R9: A command pulse while running starts a stop. The block keeps claiming slots in turn while the next one is usable, raises no underrun, and returns to idle (`tx_active`=0) once the next slot is unusable and the queue is empty. Command pulses while stopping are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 5 | Host write address (slot bytes and count words) |
| wr_data | input | 8 | Host write data |
| cmd_xmit | input | 1 | Start/stop command pulse |
| bit_en | input | 1 | Line side accepts the presented bit |
| tx_bit | output | 1 | Serial data bit |
| tx_valid | output | 1 | `tx_bit` holds a bit to send |
| buf_free_irq | output | 2 | One-cycle pulse per slot when it is claimed |
| err_irq | output | 1 | One-cycle underrun pulse |
| tx_active | output | 1 | Transmission running or stopping |
| status_words | output | 16 | Count words of slot 1 and slot 0 |

## Verification
The bench builds the block with its defaults of 8 bytes per slot and a 16-byte queue. With those values two full slots exactly fill the queue, so the back-pressure stall of R6 is reached after a handful of host writes with the line side paused. In the same state a stop request is left pending behind two more posted slots. The small slot size also keeps every full-slot transfer short enough to check bit by bit against a scoreboard at different line rates.

// File: rtl/txmb_pkg.sv
// Shared definitions for the transmit mailbox.
// Assumes: byte-wide host data, exactly two mailbox slots.
package txmb_pkg;
    localparam int BYTE_W = 8;
    localparam int NSLOT  = 2;

    typedef enum logic [1:0] {
        MB_IDLE  = 2'd0,
        MB_RUN   = 2'd1,
        MB_DRAIN = 2'd2
    } mb_mode_e;
endpackage

// File: rtl/txmb_bufregs.sv
// Mailbox slot storage: two slots of data bytes plus a count word each.
// Assumes: BUF_BYTES is a power of two; a claim (take) wins over a host
// count write in the same cycle.
module txmb_bufregs
    import txmb_pkg::*;
#(
    parameter int BUF_BYTES = 8,
    parameter int STAT_W    = 8,
    parameter int ADDR_W    = $clog2(BUF_BYTES) + 2,
    parameter int CNT_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [BYTE_W-1:0]           wr_data,
    input  logic [NSLOT-1:0]            take,
    input  logic                        sel,
    output logic [NSLOT-1:0]            valid,
    output logic [BUF_BYTES*BYTE_W-1:0] sel_bytes,
    output logic [CNT_W-1:0]            sel_cnt,
    output logic [NSLOT*STAT_W-1:0]     status_words
);
    localparam int BYTE_BITS = $clog2(BUF_BYTES);
    localparam int IDX_BIT   = BYTE_BITS;
    localparam int REG_BIT   = BYTE_BITS + 1;

    logic [BYTE_W-1:0] data_q [NSLOT][BUF_BYTES];
    logic [STAT_W-1:0] stat_q [NSLOT];

    // Count words: host writes, cleared when the slot is claimed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NSLOT; b++) stat_q[b] <= '0;
        end else begin
            for (int b = 0; b < NSLOT; b++) begin
                if (take[b])
                    stat_q[b] <= '0;
                else if (wr_en && wr_addr[REG_BIT] && (int'(wr_addr[0]) == b))
                    stat_q[b] <= STAT_W'(wr_data);
            end
        end
    end

    // Data bytes: host writes accepted only into a slot whose count is zero.
    always_ff @(posedge clk) begin
        for (int b = 0; b < NSLOT; b++) begin
            if (wr_en && !wr_addr[REG_BIT] && (int'(wr_addr[IDX_BIT]) == b)
                && (stat_q[b] == '0))
                data_q[b][wr_addr[BYTE_BITS-1:0]] <= wr_data;
        end
    end

    // Usable-slot flags, selected slot contents and exported counts.
    always_comb begin
        for (int b = 0; b < NSLOT; b++) begin
            valid[b] = (stat_q[b] != '0) && (stat_q[b] <= STAT_W'(BUF_BYTES));
            status_words[b*STAT_W +: STAT_W] = stat_q[b];
        end
        for (int i = 0; i < BUF_BYTES; i++)
            sel_bytes[i*BYTE_W +: BYTE_W] = data_q[sel][i];
        sel_cnt = stat_q[sel][CNT_W-1:0];
    end

    AST_TAKE_USABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|take) |-> ((stat_q[sel] != '0) && (stat_q[sel] <= STAT_W'(BUF_BYTES)))); // R8
    AST_SLOT0_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        take[0] |=> (stat_q[0] == '0)); // R3
    AST_SLOT1_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        take[1] |=> (stat_q[1] == '0)); // R3
endmodule

// File: rtl/txmb_queue.sv
// Byte queue plus LSB-first serializer with a valid/enable bit handshake.
// Assumes: QUEUE_BYTES is a power of two and at least BUF_BYTES; the
// pusher only pushes when room is asserted.
module txmb_queue
    import txmb_pkg::*;
#(
    parameter int BUF_BYTES   = 8,
    parameter int QUEUE_BYTES = 16,
    parameter int CNT_W       = $clog2(BUF_BYTES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [CNT_W-1:0]            push_cnt,
    input  logic [BUF_BYTES*BYTE_W-1:0] push_bytes,
    input  logic                        bit_en,
    output logic                        tx_bit,
    output logic                        tx_valid,
    output logic                        room,
    output logic                        empty
);
    localparam int PTR_W = $clog2(QUEUE_BYTES);
    localparam int QC_W  = $clog2(QUEUE_BYTES + 1) + 1;
    localparam int BC_W  = $clog2(BYTE_W + 1);

    logic [BYTE_W-1:0] mem [QUEUE_BYTES];
    logic [PTR_W-1:0]  wptr_q, rptr_q;
    logic [QC_W-1:0]   qcnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [BC_W-1:0]   bits_q;
    logic              load;
    logic [QC_W-1:0]   push_amt;

    // Queue status and serializer load decision.
    always_comb begin
        load     = (bits_q == '0) && (qcnt_q != '0);
        push_amt = push ? QC_W'(push_cnt) : '0;
        room     = (QC_W'(QUEUE_BYTES) - qcnt_q) >= QC_W'(BUF_BYTES);
        empty    = (qcnt_q == '0) && (bits_q == '0);
        tx_valid = (bits_q != '0);
        tx_bit   = shreg_q[0];
    end

    // Byte storage: a claimed slot lands in one cycle.
    always_ff @(posedge clk) begin
        for (int i = 0; i < BUF_BYTES; i++) begin
            if (push && (i < int'(push_cnt)))
                mem[wptr_q + PTR_W'(i)] <= push_bytes[i*BYTE_W +: BYTE_W];
        end
    end

    // Pointers and occupancy of the byte queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            qcnt_q <= '0;
        end else begin
            wptr_q <= wptr_q + PTR_W'(push_amt);
            rptr_q <= rptr_q + PTR_W'(load);
            qcnt_q <= qcnt_q + push_amt - QC_W'(load);
        end
    end

    // Serializer: load a byte when idle, shift right on each accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            bits_q  <= '0;
        end else if (load) begin
            shreg_q <= mem[rptr_q];
            bits_q  <= BC_W'(BYTE_W);
        end else if (tx_valid && bit_en) begin
            shreg_q <= shreg_q >> 1;
            bits_q  <= bits_q - 1'b1;
        end
    end

    always_comb begin
        if (rst_n) AST_NO_OVERFLOW: assert (qcnt_q <= QC_W'(QUEUE_BYTES)); // R6
    end
    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !bit_en) |=> (tx_valid && $stable(tx_bit))); // R5
endmodule

// File: rtl/txmb_ctrl.sv
// Mailbox sequencer: start/stop mode, alternating slot choice, claim
// decision and the slot-free and underrun interrupt pulses.
// Assumes: cmd_xmit is a single-cycle pulse per command.
module txmb_ctrl
    import txmb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_xmit,
    input  logic [NSLOT-1:0] valid,
    input  logic             room,
    input  logic             queue_empty,
    output logic [NSLOT-1:0] take,
    output logic             sel,
    output logic             active,
    output logic [NSLOT-1:0] buf_free_irq,
    output logic             err_irq
);
    mb_mode_e mode_q;
    logic     sel_q;
    logic     take_any;
    logic     underrun, under_q;

    // Claim and underrun conditions for the current cycle.
    always_comb begin
        take_any = (mode_q != MB_IDLE) && valid[sel_q] && room;
        take     = take_any ? (sel_q ? 2'b10 : 2'b01) : 2'b00;
        underrun = (mode_q == MB_RUN) && (valid == '0) && queue_empty;
        sel      = sel_q;
        active   = (mode_q != MB_IDLE);
    end

    // Mode sequencing: idle -> run on command, run -> drain on command,
    // drain -> idle once the next slot is unusable and nothing is queued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MB_IDLE;
        end else begin
            case (mode_q)
                MB_IDLE:  if (cmd_xmit) mode_q <= MB_RUN;
                MB_RUN:   if (cmd_xmit) mode_q <= MB_DRAIN;
                MB_DRAIN: if (!valid[sel_q] && queue_empty) mode_q <= MB_IDLE;
                default:  mode_q <= MB_IDLE;
            endcase
        end
    end

    // Slot pointer: reset to slot 0 on start, flip after every claim.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= 1'b0;
        else if ((mode_q == MB_IDLE) && cmd_xmit)
            sel_q <= 1'b0;
        else if (take_any)
            sel_q <= ~sel_q;
    end

    // Interrupt pulses: slot-free on a claim, underrun on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_free_irq <= '0;
            under_q      <= 1'b0;
            err_irq      <= 1'b0;
        end else begin
            buf_free_irq <= take;
            under_q      <= underrun;
            err_irq      <= underrun && !under_q;
        end
    end

    AST_ONE_FREE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(buf_free_irq)); // R3
    AST_START_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> (sel_q == 1'b0)); // R4
    AST_ERR_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> ($past(mode_q) == MB_RUN)); // R7
    AST_NO_ERR_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MB_DRAIN) |=> !err_irq); // R9
endmodule

// File: rtl/tx_mailbox.sv
// Top of the double-buffered transmit mailbox: slot storage, sequencer
// and byte queue/serializer.
// Assumes: synchronous active-low reset, host writes one byte per cycle.
module tx_mailbox
    import txmb_pkg::*;
#(
    parameter  int BUF_BYTES   = 8,
    parameter  int QUEUE_BYTES = 16,
    parameter  int STAT_W      = 8,
    localparam int ADDR_W      = $clog2(BUF_BYTES) + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [7:0]              wr_data,
    input  logic                    cmd_xmit,
    input  logic                    bit_en,
    output logic                    tx_bit,
    output logic                    tx_valid,
    output logic [1:0]              buf_free_irq,
    output logic                    err_irq,
    output logic                    tx_active,
    output logic [2*STAT_W-1:0]     status_words
);
    localparam int CNT_W = $clog2(BUF_BYTES + 1);

    logic [NSLOT-1:0]            valid, take;
    logic                        sel, room, queue_empty;
    logic [BUF_BYTES*BYTE_W-1:0] sel_bytes;
    logic [CNT_W-1:0]            sel_cnt;

    txmb_bufregs #(
        .BUF_BYTES (BUF_BYTES),
        .STAT_W    (STAT_W),
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W)
    ) i_bufregs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .take         (take),
        .sel          (sel),
        .valid        (valid),
        .sel_bytes    (sel_bytes),
        .sel_cnt      (sel_cnt),
        .status_words (status_words)
    );

    txmb_ctrl i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_xmit     (cmd_xmit),
        .valid        (valid),
        .room         (room),
        .queue_empty  (queue_empty),
        .take         (take),
        .sel          (sel),
        .active       (tx_active),
        .buf_free_irq (buf_free_irq),
        .err_irq      (err_irq)
    );

    txmb_queue #(
        .BUF_BYTES   (BUF_BYTES),
        .QUEUE_BYTES (QUEUE_BYTES),
        .CNT_W       (CNT_W)
    ) i_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (|take),
        .push_cnt   (sel_cnt),
        .push_bytes (sel_bytes),
        .bit_en     (bit_en),
        .tx_bit     (tx_bit),
        .tx_valid   (tx_valid),
        .room       (room),
        .empty      (queue_empty)
    );

    AST_CLAIM_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (|take) |-> room); // R6
endmodule

// File: tb/test_tx_mailbox.sv
// Scoreboard bench: post tasks push expected bits and slot claims into
// queues; a monitor pops and compares them as the design produces them.
module test_tx_mailbox;
    localparam int AW = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        cmd_xmit = 1'b0;
    logic        bit_en = 1'b0;
    logic        tx_bit, tx_valid, err_irq, tx_active;
    logic [1:0]  buf_free_irq;
    logic [15:0] status_words;

    bit bitq[$];
    int slotq[$];
    int total = 0, bad = 0, err_seen = 0, cyc = 0, ben_ctr = 0;
    bit ben_on = 0;
    int ben_div = 1;

    always #2 clk = ~clk;

    tx_mailbox i_tx_mailbox (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cmd_xmit(cmd_xmit), .bit_en(bit_en),
        .tx_bit(tx_bit), .tx_valid(tx_valid), .buf_free_irq(buf_free_irq),
        .err_irq(err_irq), .tx_active(tx_active), .status_words(status_words)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Line-side acceptance pattern.
    always @(posedge clk) begin
        #1;
        ben_ctr++;
        bit_en = ben_on && ((ben_ctr % ben_div) == 0);
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Monitor: compare bits and slot claims against the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid && bit_en) begin
                if (bitq.size() == 0)
                    chk(0, "R5 unexpected bit", int'(tx_bit), -1);
                else begin
                    automatic bit e = bitq.pop_front();
                    chk(tx_bit == e, "R5 serial bit", int'(tx_bit), int'(e));
                end
            end
            if (buf_free_irq != 2'b00) begin
                chk($countones(buf_free_irq) == 1, "R3 one slot irq", int'(buf_free_irq), 1);
                if (slotq.size() == 0)
                    chk(0, "R4 unexpected claim", int'(buf_free_irq), 0);
                else begin
                    automatic int e = slotq.pop_front();
                    chk(buf_free_irq == (2'b01 << e), "R4 claim order",
                        int'(buf_free_irq), 1 << e);
                end
            end
            if (err_irq) err_seen++;
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic cmd();
        cmd_xmit = 1'b1;
        @(posedge clk); #1;
        cmd_xmit = 1'b0;
    endtask

    // Fill a slot and post its count; record what must come out.
    task automatic post(input int s, input int n, input logic [7:0] seed);
        for (int j = 0; j < n; j++) begin
            automatic logic [7:0] d = seed + 8'(j * 37);
            wr(AW'(s * 8 + j), d);
            for (int k = 0; k < 8; k++) bitq.push_back(d[k]);
        end
        slotq.push_back(s);
        wr(AW'(16 + s), 8'(n));
    endtask

    task automatic wait_bits(input int limit);
        for (int i = 0; i < limit; i++) begin
            if (bitq.size() == 0 && !tx_valid) break;
            @(posedge clk); #1;
        end
    endtask

    initial begin
        int e0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(status_words == 16'h0, "R1 counts", int'(status_words), 0);
        chk(!tx_valid, "R1 tx_valid", int'(tx_valid), 0);
        chk(!tx_active, "R1 tx_active", int'(tx_active), 0);
        chk(!err_irq && buf_free_irq == 2'b00, "R1 irqs", int'(buf_free_irq), 0);
        @(posedge clk); #1;

        // Session A: R2 write map, ignored write into a posted slot, R4 start.
        wr(5'd16, 8'd1);
        for (int k = 0; k < 8; k++) bitq.push_back(k == 1 || k == 3 || k == 4 || k == 6);
        slotq.push_back(0);
        wr_en = 1'b1; wr_addr = 5'd16; wr_data = 8'd0; @(posedge clk); #1; wr_en = 1'b0;
        wr(5'd0, 8'h5A);
        wr(5'd16, 8'd1);
        wr(5'd0, 8'hFF);                     // R2 ignored: count nonzero
        post(1, 3, 8'h81);
        @(negedge clk);
        chk(status_words == 16'h0301, "R2 count words", int'(status_words), 16'h0301);
        @(posedge clk); #1;
        ben_on = 1; ben_div = 1;
        cmd();
        wait_bits(500);
        repeat (5) @(posedge clk);
        #1;
        @(negedge clk);
        chk(bitq.size() == 0, "R5 all bits sent", bitq.size(), 0);
        chk(status_words == 16'h0, "R3 counts cleared", int'(status_words), 0);
        chk(err_seen == 1, "R7 underrun once", err_seen, 1);
        chk(tx_active, "R4 still running", int'(tx_active), 1);

        // R6 back-pressure, then R9 stop with two slots still pending.
        ben_on = 0;
        @(posedge clk); #1;
        post(0, 8, 8'h13);
        post(1, 8, 8'h64);
        post(0, 8, 8'hA7);
        post(1, 8, 8'h2C);
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk(status_words == 16'h0808, "R6 slots wait for room", int'(status_words), 16'h0808);
        @(posedge clk); #1;
        e0 = err_seen;
        cmd();
        cmd();                               // R9 ignored while stopping
        ben_on = 1; ben_div = 3;
        for (int i = 0; i < 3000; i++) begin
            if (!tx_active) break;
            @(posedge clk); #1;
        end
        @(negedge clk);
        chk(!tx_active, "R9 back to idle", int'(tx_active), 0);
        chk(bitq.size() == 0, "R9 pending slots drained", bitq.size(), 0);
        chk(slotq.size() == 0, "R9 all claims seen", slotq.size(), 0);
        chk(err_seen == e0, "R9 no underrun while stopping", err_seen, e0);
        chk(status_words == 16'h0, "R9 counts cleared", int'(status_words), 0);
        @(posedge clk); #1;

        // R8 oversized count is never claimed.
        wr(5'd16, 8'd9);
        e0 = err_seen;
        cmd();
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk(status_words[7:0] == 8'd9, "R8 count kept", int'(status_words[7:0]), 9);
        chk(!tx_valid, "R8 nothing sent", int'(tx_valid), 0);
        chk(err_seen == e0 + 1, "R7 underrun with unusable slot", err_seen, e0 + 1);
        @(posedge clk); #1;
        cmd();
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(!tx_active, "R9 stop with nothing posted", int'(tx_active), 0);
        chk(slotq.size() == 0, "R8 no claim", slotq.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule